// File: doc/BRIEF.md
# External Bus Wait-State and READY Controller

This block runs one external bus transfer at a time and decides how many clocks each transfer lasts. A request carries the direction and a per-transfer setting: a count of fixed wait states, whether an external active-low READY line may stretch the transfer, whether that line is used directly or through a two-flop synchronizer, whether the bus is address/data multiplexed, and whether a tristate recovery clock follows the transfer.

While a transfer runs, the block holds the read or the write strobe low. The fixed wait states run first. After that, READY is checked once per clock until it is seen low. When READY stretching is off, the strobe returns high as soon as the fixed wait states are done. After the strobe rises, zero, one or two extra busy clocks follow, depending on the multiplexed and tristate settings. The block then gives a one-clock done pulse and is ready for the next request.

Top module: `buswait_ctrl`

## Requirements
- R1: During and after reset, before any request, rd_n and wr_n are high and busy and done are low.
- R2: A request (req_valid high) is taken only in a clock where busy is low. In the next clock, busy is high and rd_n goes low for req_write=0, or wr_n goes low for req_write=1. A req_valid pulse while busy is high starts no transfer.
- R3: The strobe stays low for at least req_ws+1 clocks. A low READY during the fixed wait states does not shorten the transfer.
- R4: With READY enabled in synchronous mode, rdy_n is checked at the end of each strobe clock from clock index req_ws onward (index 0 is the first strobe clock). The strobe ends after the first checked clock in which rdy_n is low.
- R5: With READY disabled, the strobe is low for exactly req_ws+1 clocks, whatever rdy_n does.
- R6: In asynchronous mode, a low rdy_n ends the transfer two clocks later than it would in synchronous mode. The synchronizer holds its not-ready value until the fixed wait states are over, so a low level seen earlier cannot end the transfer.
- R7: With req_mux=1, busy stays high for one clock with both strobes high after the strobe rises.
- R8: With req_tri=1, one further busy clock is added after the command. Multiplexed with tristate gives two such clocks, and neither gives none.
- R9: done is high for exactly one clock: the first clock with busy low after a transfer. A new request may be taken in that same clock.
- R10: rd_n and wr_n are never low together, and a strobe is low only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_ws | input | WS_W | Fixed wait-state count |
| req_rdy_en | input | 1 | Allow READY to stretch the transfer |
| req_rdy_async | input | 1 | Route READY through the synchronizer |
| req_mux | input | 1 | Multiplexed bus: one extra clock after the command |
| req_tri | input | 1 | Append a tristate recovery clock |
| rdy_n | input | 1 | External READY, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Transfer or post-transfer clock in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Two things can happen in the same clock: the done pulse of one transfer and the acceptance of the next request. The bench provokes this by issuing the next request as soon as busy reads low. Each result is judged by checking the done pulse together with the strobe lengths and post-command counts of both transfers. The bench also lowers READY during the fixed wait states, while a count is still running, and checks that the strobe length depends only on the count.

// File: rtl/buswait_pkg.sv
package buswait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_MUXW = 2'd2,
    ST_TRIW = 2'd3
  } bw_state_e;

  typedef struct packed {
    logic write;
    logic rdy_en;
    logic rdy_async;
    logic mux;
    logic tri_ws;
  } bw_mode_t;

endpackage

// File: rtl/bw_wait_counter.sv
module bw_wait_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/bw_ready_sampler.sv
module bw_ready_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic window,
  input  logic async_mode,
  input  logic rdy_n,
  output logic ready_seen
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  // Outside the sampling window every stage is forced to "not ready".
  always_comb begin
    chain_d[0] = window ? rdy_n : 1'b1;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
      always_comb begin
        chain_d[g] = window ? chain_q[g-1] : 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign ready_seen = async_mode ? ~chain_q[SYNC_STAGES-1] : ~rdy_n;

endmodule

// File: rtl/bw_seq_fsm.sv
module bw_seq_fsm
  import buswait_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  bw_mode_t req_mode,
  input  logic     cnt_zero,
  input  logic     ready_seen,
  output logic     accept,
  output logic     in_cmd,
  output logic     async_sel,
  output logic     rd_n,
  output logic     wr_n,
  output logic     busy,
  output logic     done
);

  bw_state_e state_q, state_d;
  bw_mode_t  mode_q, mode_d;
  logic      rd_n_q, rd_n_d;
  logic      wr_n_q, wr_n_d;
  logic      busy_q, busy_d;
  logic      done_q, done_d;
  logic      cmd_end;
  bw_state_e after_cmd;

  assign cmd_end = cnt_zero && (!mode_q.rdy_en || ready_seen);

  always_comb begin
    if (mode_q.mux) begin
      after_cmd = ST_MUXW;
    end else if (mode_q.tri_ws) begin
      after_cmd = ST_TRIW;
    end else begin
      after_cmd = ST_IDLE;
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          mode_d  = req_mode;
          state_d = ST_CMD;
        end
      end
      ST_CMD: begin
        if (cmd_end) begin
          state_d = after_cmd;
        end
      end
      ST_MUXW: begin
        state_d = mode_q.tri_ws ? ST_TRIW : ST_IDLE;
      end
      ST_TRIW: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registered outputs decoded from the next state
  always_comb begin
    rd_n_d = !((state_d == ST_CMD) && !mode_d.write);
    wr_n_d = !((state_d == ST_CMD) &&  mode_d.write);
    busy_d = (state_d != ST_IDLE);
    done_d = (state_d == ST_IDLE) && (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
    end
  end

  assign in_cmd    = (state_q == ST_CMD);
  assign async_sel = mode_q.rdy_async;
  assign rd_n      = rd_n_q;
  assign wr_n      = wr_n_q;
  assign busy      = busy_q;
  assign done      = done_q;

endmodule

// File: rtl/buswait_ctrl.sv
module buswait_ctrl
  import buswait_pkg::*;
#(
  parameter int WS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [WS_W-1:0] req_ws,
  input  logic            req_rdy_en,
  input  logic            req_rdy_async,
  input  logic            req_mux,
  input  logic            req_tri,
  input  logic            rdy_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            busy,
  output logic            done
);

  bw_mode_t req_mode;
  logic     accept;
  logic     in_cmd;
  logic     async_sel;
  logic     cnt_zero;
  logic     ready_seen;
  logic     window;

  always_comb begin
    req_mode.write     = req_write;
    req_mode.rdy_en    = req_rdy_en;
    req_mode.rdy_async = req_rdy_async;
    req_mode.mux       = req_mux;
    req_mode.tri_ws    = req_tri;
  end

  assign window = in_cmd && cnt_zero;

  bw_wait_counter #(.CNT_W(WS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (req_ws),
    .run      (in_cmd),
    .zero     (cnt_zero)
  );

  bw_ready_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .window     (window),
    .async_mode (async_sel),
    .rdy_n      (rdy_n),
    .ready_seen (ready_seen)
  );

  bw_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .cnt_zero   (cnt_zero),
    .ready_seen (ready_seen),
    .accept     (accept),
    .in_cmd     (in_cmd),
    .async_sel  (async_sel),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [WS_W-1:0] req_ws,
  input logic            req_rdy_en,
  input logic            rd_n,
  input logic            wr_n,
  input logic            busy,
  input logic            done
);

  logic            strobe_low;
  logic            prev_low;
  logic [15:0]     len_q;
  logic [WS_W-1:0] ws_lat;
  logic            en_lat;
  logic [15:0]     min_len;

  assign strobe_low = !rd_n || !wr_n;
  assign min_len    = 16'(ws_lat) + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0;
      len_q    <= '0;
      ws_lat   <= '0;
      en_lat   <= 1'b0;
    end else begin
      prev_low <= strobe_low;
      if (req_valid && !busy) begin
        len_q  <= '0;
        ws_lat <= req_ws;
        en_lat <= req_rdy_en;
      end else if (strobe_low) begin
        len_q <= len_q + 16'd1;
      end
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> busy);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_min_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_low && !strobe_low) |-> (len_q >= min_len));

  p_fixed_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_low && !strobe_low && !en_lat) |-> (len_q == min_len));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (busy && strobe_low));

endmodule

bind buswait_ctrl bw_checker #(.WS_W(WS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ws     (req_ws),
  .req_rdy_en (req_rdy_en),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .busy       (busy),
  .done       (done)
);

// File: tb/buswait_ctrl_test.sv
`timescale 1ns/1ps
module buswait_ctrl_test;

  localparam int WS_W = 4;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_write;
  logic [WS_W-1:0] req_ws;
  logic            req_rdy_en;
  logic            req_rdy_async;
  logic            req_mux;
  logic            req_tri;
  logic            rdy_n;
  logic            rd_n;
  logic            wr_n;
  logic            busy;
  logic            done;

  typedef struct {
    bit    wr;
    int    cmd_len;
    int    post_len;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_errors;
  int   cycles;
  bit   in_cyc;
  bit   cur_wr;
  int   low_cnt;
  int   post_cnt;

  buswait_ctrl #(.WS_W(WS_W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_ws        (req_ws),
    .req_rdy_en    (req_rdy_en),
    .req_rdy_async (req_rdy_async),
    .req_mux       (req_mux),
    .req_tri       (req_tri),
    .rdy_n         (rdy_n),
    .rd_n          (rd_n),
    .wr_n          (wr_n),
    .busy          (busy),
    .done          (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // driver: waits for idle, issues one request, shapes READY, pushes expectation
  task automatic issue(input bit wr, input int ws, input bit en, input bit asy,
                       input bit mux, input bit tw, input int hold, input string tag);
    exp_t e;
    int   base;
    @(negedge clk);
    while (busy) @(negedge clk);
    base = (ws > hold) ? ws : hold;
    e.wr  = wr;
    e.tag = tag;
    if (!en)      e.cmd_len = ws + 1;
    else if (asy) e.cmd_len = base + 3;
    else          e.cmd_len = base + 1;
    e.post_len = int'(mux) + int'(tw);
    exp_q.push_back(e);
    req_valid     = 1'b1;
    req_write     = wr;
    req_ws        = WS_W'(ws);
    req_rdy_en    = en;
    req_rdy_async = asy;
    req_mux       = mux;
    req_tri       = tw;
    rdy_n         = (hold > 0);
    for (int j = 0; j <= hold; j++) begin
      @(negedge clk);
      if (j == 0) req_valid = 1'b0;
      rdy_n = (j < hold);
    end
  endtask

  // monitor: measures each transfer and compares with the queue head
  always @(negedge clk) begin
    if (!rst_n) begin
      in_cyc   = 1'b0;
      low_cnt  = 0;
      post_cnt = 0;
    end else begin
      if (!rd_n && !wr_n) chk(1'b0, "R10", "both strobes low", 1, 0);
      if (!rd_n || !wr_n) begin
        if (!busy) chk(1'b0, "R10", "strobe low while idle", 0, 1);
        if (!in_cyc) begin
          in_cyc   = 1'b1;
          low_cnt  = 0;
          post_cnt = 0;
          cur_wr   = !wr_n;
        end
        low_cnt++;
      end else if (in_cyc && busy) begin
        post_cnt++;
      end else if (in_cyc) begin
        in_cyc = 1'b0;
        chk(done == 1'b1, "R9", "done at end of transfer", int'(done), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "transfer with no request", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cur_wr == e.wr, "R2", "strobe direction", int'(cur_wr), int'(e.wr));
          chk(low_cnt == e.cmd_len, e.tag, "strobe length", low_cnt, e.cmd_len);
          chk(post_cnt == e.post_len, (e.post_len > 1) ? "R8" : "R7",
              "post-command clocks", post_cnt, e.post_len);
        end
      end else if (done) begin
        chk(1'b0, "R9", "stray done", 1, 0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; cycles = 0;
    req_valid = 1'b0; req_write = 1'b0; req_ws = '0; req_rdy_en = 1'b0;
    req_rdy_async = 1'b0; req_mux = 1'b0; req_tri = 1'b0; rdy_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_n == 1'b1 && wr_n == 1'b1, "R1", "strobes in reset", int'({rd_n, wr_n}), 3);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_n == 1'b1 && wr_n == 1'b1 && !busy && !done, "R1", "idle after reset",
        int'({rd_n, wr_n, busy, done}), 12);

    issue(0, 0, 1, 0, 0, 0, 0, "R4");   // shortest synchronous read
    issue(1, 3, 1, 0, 0, 0, 0, "R3");   // READY low during fixed waits
    issue(0, 1, 1, 0, 0, 0, 4, "R4");   // READY held off into sample window
    issue(1, 2, 0, 0, 0, 0, 6, "R5");   // READY disabled, high level ignored
    issue(0, 0, 1, 1, 0, 0, 0, "R6");   // asynchronous, steady low
    issue(1, 2, 1, 1, 0, 0, 4, "R6");   // asynchronous, late READY
    issue(0, 0, 1, 0, 1, 0, 0, "R7");   // multiplexed
    issue(1, 1, 0, 0, 0, 1, 0, "R8");   // tristate only
    issue(0, 0, 1, 0, 1, 1, 0, "R8");   // multiplexed plus tristate
    issue(1, 15, 0, 0, 0, 0, 0, "R5");  // largest fixed count
    issue(0, 0, 0, 0, 0, 0, 0, "R9");   // back-to-back pair
    issue(1, 0, 0, 0, 0, 0, 0, "R9");

    // R2: request pulse while busy must start nothing
    issue(0, 6, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    while (exp_q.size() != 0 || in_cyc || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!busy && rd_n && wr_n, "R2", "idle after ignored request",
        int'({busy, rd_n, wr_n}), 3);
    chk(exp_q.size() == 0, "R9", "all transfers completed", exp_q.size(), 0);
    finish_run();
  end

endmodule